// File: doc/BRIEF.md
# Machine Timer and Software Interrupt Unit

This block is the per-hart interrupt source for a single processor core. It holds a one-bit software interrupt flag, a 64-bit time counter that runs on its own and a 64-bit compare value. It drives two level outputs to the hart: software pending and timer pending. Each 64-bit value is split into a low and a high 32-bit half. Software reads and writes every register one byte at a time over a simple byte bus with 16-bit offsets.

The time counter advances by one on every cycle in which `tick` is high. The carry out of the low half increments the high half. Timer pending is a level. It is high while the full 64-bit time is at or above the compare value, taking the high half first. The comparison is armed only while both compare halves are nonzero.

Reads are combinational and have no side effects. Writes take effect at the rising clock edge.

Top module: `tmr_core_local`

## Requirements
- R1: A write to offset 0x0000 keeps only bit 0 of the write data. A read of offset 0x0000 returns that bit in bit 0, with zeros above it. `sw_irq_pend` equals the stored bit.
- R2: Offsets 0x0001 to 0x0003 read as 0. Writes to them have no effect.
- R3: The compare value sits at offsets 0x4000 to 0x4007: low half at 0x4000 to 0x4003, high half at 0x4004 to 0x4007. Bytes are little-endian, so the lowest offset holds bits 7:0.
- R4: The time counter sits at offsets 0xBFF8 to 0xBFFF with the same half order and byte order as the compare value.
- R5: A byte write changes only the addressed byte lane of the selected half. The other three lanes keep their values.
- R6: The time counter increments by one in each cycle where `tick` is high. When the low half wraps from all ones to zero, the high half increments. The counter holds its value when `tick` is low.
- R7: `tmr_irq_pend` is high when time is greater than or equal to compare as unsigned 64-bit values, with the high halves compared first.
- R8: `tmr_irq_pend` stays low while either compare half is zero, whatever the time value.
- R9: After reset, every register and both pending outputs are zero.
- R10: Any offset not listed in R1, R3 or R4 reads as 0. Writes to such offsets change no register.
- R11: In a cycle where a time byte is written, the written value is stored and the counter does not increment, even if `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Increment enable for the time counter |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 16 | Byte offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the same cycle as a read access |
| sw_irq_pend | output | 1 | Software interrupt pending |
| tmr_irq_pend | output | 1 | Timer interrupt pending |

## Verification
A stored byte landing in the wrong lane or the wrong half shows at `bus_rdata` on the first read of that offset. It also moves the point at which `tmr_irq_pend` rises. A missing or doubled carry shows on the readback taken in the cycle after the tick in which the low half wraps. An increment that wins over a bus write shows as a written byte that is off by one on the very next read.

Errors in the compare arming or in the half ordering appear as `tmr_irq_pend` taking the wrong level. That level is visible as soon as the register values are set up, because the output is derived combinationally from the stored state.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned HALF_W     = 32;
  localparam int unsigned LANES      = HALF_W / 8;
  localparam int unsigned LANE_SEL_W = $clog2(LANES);

  localparam logic [ADDR_W-1:0] OFS_SWI  = 16'h0000;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 16'h4000;
  localparam logic [ADDR_W-1:0] OFS_TIME = 16'hBFF8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_SWI,
    SEL_CMP,
    SEL_TIME
  } region_e;

  typedef struct packed {
    region_e               region;
    logic                  hi;
    logic [LANE_SEL_W-1:0] lane;
  } dec_t;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int unsigned GRP_LSB = LANE_SEL_W + 1;

  always_comb begin
    dec.region = SEL_NONE;
    dec.hi     = addr[LANE_SEL_W];
    dec.lane   = addr[LANE_SEL_W-1:0];
    if (addr == OFS_SWI) begin
      dec.region = SEL_SWI;
    end else if (addr[ADDR_W-1:GRP_LSB] == OFS_CMP[ADDR_W-1:GRP_LSB]) begin
      dec.region = SEL_CMP;
    end else if (addr[ADDR_W-1:GRP_LSB] == OFS_TIME[ADDR_W-1:GRP_LSB]) begin
      dec.region = SEL_TIME;
    end
  end
endmodule

// File: rtl/tmr_half_reg.sv
module tmr_half_reg #(
  parameter int unsigned W  = 32,
  parameter int unsigned LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [LW-1:0] lane,
  input  logic [7:0]    wbyte,
  input  logic          inc_en,
  output logic [W-1:0]  q
);
  localparam int unsigned NLANE = W / 8;

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         load;

  // a bus write to this half wins over the increment
  always_comb begin
    q_nxt = q_r;
    if (wr_en) begin
      for (int i = 0; i < NLANE; i++) begin
        if (lane == LW'(i)) q_nxt[8*i +: 8] = wbyte;
      end
    end else if (inc_en) begin
      q_nxt = q_r + W'(1);
    end
  end

  assign load = wr_en | inc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (load) begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] time_lo,
  input  logic [W-1:0] time_hi,
  input  logic [W-1:0] cmp_lo,
  input  logic [W-1:0] cmp_hi,
  output logic         pend
);
  logic armed;
  logic reached;

  assign armed   = (cmp_lo != '0) && (cmp_hi != '0);
  assign reached = (time_hi > cmp_hi) ||
                   ((time_hi == cmp_hi) && (time_lo >= cmp_lo));
  assign pend    = armed && reached;
endmodule

// File: rtl/tmr_core_local.sv
module tmr_core_local
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              sw_irq_pend,
  output logic              tmr_irq_pend
);
  dec_t                   dec;
  logic                   wr;
  logic                   time_wr;
  logic                   cmp_wr;
  logic                   swi_q;
  logic                   swi_nxt;
  logic                   swi_load;
  logic [1:0][HALF_W-1:0] cmp_q;
  logic [1:0][HALF_W-1:0] time_q;

  tmr_addr_dec i_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  assign wr      = bus_valid && bus_write;
  assign time_wr = wr && (dec.region == SEL_TIME);
  assign cmp_wr  = wr && (dec.region == SEL_CMP);

  // software interrupt flag
  assign swi_load = wr && (dec.region == SEL_SWI);
  assign swi_nxt  = bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swi_q <= 1'b0;
    end else if (swi_load) begin
      swi_q <= swi_nxt;
    end
  end

  // halves: index 0 low, index 1 high
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic cmp_sel;
    logic time_sel;
    logic time_inc;

    assign cmp_sel  = cmp_wr && (dec.hi == 1'(h));
    assign time_sel = time_wr && (dec.hi == 1'(h));
    assign time_inc = tick && !time_wr && ((h == 0) || (&time_q[0]));

    tmr_half_reg #(.W(HALF_W), .LW(LANE_SEL_W)) i_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cmp_sel),
      .lane   (dec.lane),
      .wbyte  (bus_wdata),
      .inc_en (1'b0),
      .q      (cmp_q[h])
    );

    tmr_half_reg #(.W(HALF_W), .LW(LANE_SEL_W)) i_time (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (time_sel),
      .lane   (dec.lane),
      .wbyte  (bus_wdata),
      .inc_en (time_inc),
      .q      (time_q[h])
    );
  end

  tmr_cmp #(.W(HALF_W)) i_cmp_unit (
    .time_lo (time_q[0]),
    .time_hi (time_q[1]),
    .cmp_lo  (cmp_q[0]),
    .cmp_hi  (cmp_q[1]),
    .pend    (tmr_irq_pend)
  );

  // read mux
  always_comb begin
    bus_rdata = 8'h00;
    if (bus_valid && !bus_write) begin
      unique case (dec.region)
        SEL_SWI:  bus_rdata = {7'b0, swi_q};
        SEL_CMP:  bus_rdata = cmp_q[dec.hi][{dec.lane, 3'b000} +: 8];
        SEL_TIME: bus_rdata = time_q[dec.hi][{dec.lane, 3'b000} +: 8];
        default:  bus_rdata = 8'h00;
      endcase
    end
  end

  assign sw_irq_pend = swi_q;

  // assertions
  assert_sw_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == OFS_SWI) |=> (sw_irq_pend == $past(bus_wdata[0])));

  assert_pad_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr != OFS_SWI) |=> $stable(sw_irq_pend));

  assert_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !time_wr && (&time_q[0])) |=>
      ((time_q[0] == '0) && (time_q[1] == $past(time_q[1]) + HALF_W'(1))));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !time_wr) |=> $stable(time_q));

  assert_pend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_irq_pend && !(bus_valid && bus_write) && !((&time_q[0]) && (&time_q[1])))
      |=> tmr_irq_pend);
endmodule

// File: tb/test_tmr_core_local.sv
module test_tmr_core_local;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        bus_valid;
  logic        bus_write;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        sw_irq_pend;
  logic        tmr_irq_pend;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  tmr_core_local i_tmr_core_local (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .sw_irq_pend  (sw_irq_pend),
    .tmr_irq_pend (tmr_irq_pend)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        failures++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd_byte(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic wr32(input logic [15:0] base, input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr_byte(base + 16'(i), v[8*i +: 8]);
  endtask

  task automatic rd32(input logic [15:0] base, output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd_byte(base + 16'(i), b);
      v[8*i +: 8] = b;
    end
  endtask

  task automatic set_time(input logic [31:0] hi, input logic [31:0] lo);
    wr32(16'hBFF8, lo);
    wr32(16'hBFFC, hi);
  endtask

  task automatic set_cmp(input logic [31:0] hi, input logic [31:0] lo);
    wr32(16'h4000, lo);
    wr32(16'h4004, hi);
  endtask

  task automatic one_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd32(16'h4000, v); check("R9 cmp lo", v, 0);
    rd32(16'h4004, v); check("R9 cmp hi", v, 0);
    rd32(16'hBFF8, v); check("R9 time lo", v, 0);
    rd32(16'hBFFC, v); check("R9 time hi", v, 0);
    check("R9 sw pend", sw_irq_pend, 0);
    check("R9 tmr pend", tmr_irq_pend, 0);
  endtask

  task automatic t_swi();
    logic [7:0] b;
    wr_byte(16'h0001, 8'hFF);
    wr_byte(16'h0002, 8'hFF);
    wr_byte(16'h0003, 8'hFF);
    check("R2 pad write no effect", sw_irq_pend, 0);
    rd_byte(16'h0000, b); check("R2 flag unchanged", b, 8'h00);
    wr_byte(16'h0000, 8'hFE);
    check("R1 bit0 only clear", sw_irq_pend, 0);
    wr_byte(16'h0000, 8'hFF);
    rd_byte(16'h0000, b); check("R1 read bit0", b, 8'h01);
    check("R1 sw pend set", sw_irq_pend, 1);
    for (int i = 1; i < 4; i++) begin
      rd_byte(16'(i), b); check("R2 pad reads 0", b, 8'h00);
    end
    wr_byte(16'h0002, 8'h00);
    check("R2 pad write keeps flag", sw_irq_pend, 1);
    wr_byte(16'h0000, 8'h00);
    check("R1 sw pend clear", sw_irq_pend, 0);
  endtask

  task automatic t_map_lanes();
    logic [31:0] v;
    logic [7:0]  b;
    set_cmp(32'h89AB_CDEF, 32'h0123_4567);
    rd_byte(16'h4000, b); check("R3 cmp byte0", b, 8'h67);
    rd_byte(16'h4007, b); check("R3 cmp byte7", b, 8'h89);
    wr_byte(16'h4005, 8'h5A);
    rd32(16'h4004, v); check("R5 cmp lane merge", v, 32'h89AB_5AEF);
    rd32(16'h4000, v); check("R5 cmp lo untouched", v, 32'h0123_4567);
    set_time(32'hDEAD_BEEF, 32'hCAFE_F00D);
    rd_byte(16'hBFF8, b); check("R4 time byte0", b, 8'h0D);
    rd_byte(16'hBFFF, b); check("R4 time byte7", b, 8'hDE);
    wr_byte(16'hBFFA, 8'h11);
    rd32(16'hBFF8, v); check("R5 time lane merge", v, 32'hCA11_F00D);
    set_cmp(32'h0, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    set_time(32'h5, 32'hFFFF_FFFE);
    one_tick();
    rd32(16'hBFF8, v); check("R6 inc lo", v, 32'hFFFF_FFFF);
    rd32(16'hBFFC, v); check("R6 hi held", v, 32'h5);
    one_tick();
    rd32(16'hBFF8, v); check("R6 wrap lo", v, 32'h0);
    rd32(16'hBFFC, v); check("R6 carry hi", v, 32'h6);
    repeat (3) @(negedge clk);
    rd32(16'hBFF8, v); check("R6 hold without tick", v, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    set_time(32'h6, 32'h0000_0100);
    @(negedge clk);
    tick = 1'b1; bus_valid = 1'b1; bus_write = 1'b1;
    bus_addr = 16'hBFF8; bus_wdata = 8'h42;
    @(negedge clk);
    tick = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    rd32(16'hBFF8, v); check("R11 write beats tick", v, 32'h0000_0142);
    rd32(16'hBFFC, v); check("R11 hi unchanged", v, 32'h6);
  endtask

  task automatic t_compare();
    set_cmp(32'h1, 32'h10);
    set_time(32'h1, 32'h0F);
    check("R7 below", tmr_irq_pend, 0);
    one_tick();
    check("R7 equal", tmr_irq_pend, 1);
    set_time(32'h2, 32'h0);
    check("R7 hi greater", tmr_irq_pend, 1);
    set_time(32'h0, 32'hFFFF_FFFF);
    check("R7 hi smaller", tmr_irq_pend, 0);
  endtask

  task automatic t_disarm();
    set_time(32'h5, 32'hFFFF_0000);
    set_cmp(32'h0, 32'h10);
    check("R8 hi zero disarms", tmr_irq_pend, 0);
    set_cmp(32'h1, 32'h0);
    check("R8 lo zero disarms", tmr_irq_pend, 0);
    wr_byte(16'h4000, 8'h01);
    check("R8 armed control", tmr_irq_pend, 1);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    logic [7:0]  b;
    set_cmp(32'h1111_2222, 32'h3333_4444);
    set_time(32'h5555_6666, 32'h7777_8888);
    wr_byte(16'h0004, 8'hAA);
    wr_byte(16'h4008, 8'hAA);
    wr_byte(16'h3FFF, 8'hAA);
    wr_byte(16'hBFF7, 8'hAA);
    wr_byte(16'h0010, 8'h01);
    rd_byte(16'h4008, b); check("R10 read 0x4008", b, 0);
    rd_byte(16'hBFF7, b); check("R10 read 0xBFF7", b, 0);
    rd_byte(16'h0004, b); check("R10 read 0x0004", b, 0);
    rd32(16'h4000, v); check("R10 cmp lo kept", v, 32'h3333_4444);
    rd32(16'h4004, v); check("R10 cmp hi kept", v, 32'h1111_2222);
    rd32(16'hBFF8, v); check("R10 time lo kept", v, 32'h7777_8888);
    rd32(16'hBFFC, v); check("R10 time hi kept", v, 32'h5555_6666);
    check("R10 sw pend kept", sw_irq_pend, 0);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_swi();
    t_map_lanes();
    t_count();
    t_priority();
    t_compare();
    t_disarm();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule